// File: doc/BRIEF.md
# Dual Loop Code Detector

This block watches a received serial T1 bit stream for two repeating in-band codes at once: a loop-up code and a loop-down code. Each code has its own pattern register and its own length of 1 to 8 bits. When a code has been present across one full integration window, the block sets that code's sticky flag. The flag stays set until the host clears it.

The detector is built to tolerate line errors. It does not demand an exact match. Every possible phase alignment of each pattern is scored in parallel against the incoming bits. A window counts as a detection when the best alignment shows fewer mismatches than a programmable limit, which defaults to about 2% of the window. The default window is 74,112 counted bits, roughly 48 ms at 1.544 Mbit/s, and a parameter shortens it for simulation. In framed operation, bits marked as framing positions are skipped, so the detector works on framed and unframed traffic alike.

Top module: `loopcode_watch`

## Requirements
- R1: While reset is high, and on the first cycle after it, both flags read 0.
- R2: The two codes are detected independently and concurrently, and each uses its own length. A stream carrying one code sets only that code's flag.
- R3: A code's length is programmed as length minus one. The pattern is the top bits of the 8-bit code register, with bit 7 received first. A window is WIN counted bits starting from reset. If the code is present throughout a window, the flag is 1 on the cycle after the last counted bit of that window.
- R4: Detection does not depend on where the pattern phase falls relative to the window boundary.
- R5: A window that holds fewer than ERR_LIM bit errors against the code still sets the flag.
- R6: A window that holds ERR_LIM or more bit errors against the code does not set the flag.
- R7: When framed mode is high, a bit marked as a framing position is neither counted nor compared. When framed mode is low, the same bit is counted and compared like any other bit.
- R8: Once set, a flag stays at 1 through later windows without the code. A clear pulse on that code's clear input returns the flag to 0 on the next cycle.
- R9: If a clear arrives in the same cycle as a detection for that code, the flag ends at 1.
- R10: Code register bits below the programmed length have no effect on detection.
- R11: Cycles with the bit-valid input low are ignored. They do not advance the window, the pattern phase or the error counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Received serial data bit |
| fbit_pos | input | 1 | Marks the current bit as a framing position |
| framed | input | 1 | 1: skip marked framing bits; 0: unframed stream |
| up_code | input | 8 | Loop-up pattern, bit 7 first |
| up_len | input | 3 | Loop-up pattern length minus one |
| dn_code | input | 8 | Loop-down pattern, bit 7 first |
| dn_len | input | 3 | Loop-down pattern length minus one |
| up_clr | input | 1 | Clears the loop-up flag |
| dn_clr | input | 1 | Clears the loop-down flag |
| up_flag | output | 1 | Sticky loop-up detected flag |
| dn_flag | output | 1 | Sticky loop-down detected flag |

## Verification
A host clear and a window-end detection for the same code can land in the same cycle. The bench provokes this by raising the loop-up clear together with the last counted bit of a clean loop-up window, and it expects the flag to read 1 afterwards. On separate cycles, the bench also checks that the clear alone drops the flag and that detection alone raises it. Each window's expected flag pair is queued by the driver and compared by a monitor on the cycle after the window closes.

// File: rtl/loopcode_pkg.sv
package loopcode_pkg;
  localparam int CODE_W = 8;
  localparam int LEN_W  = $clog2(CODE_W);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LEN_W-1:0]  len_t;

  // (a + b) modulo (lm1 + 1), for a, b not above lm1
  function automatic len_t phase_add(len_t a, len_t b, len_t lm1);
    logic [LEN_W:0] s;
    logic [LEN_W:0] m;
    s = {1'b0, a} + {1'b0, b};
    m = {1'b0, lm1} + {{LEN_W{1'b0}}, 1'b1};
    if (s >= m) s = s - m;
    return s[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/lc_window_timer.sv
module lc_window_timer #(
  parameter int WIN = 74112
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  output logic win_last
);
  localparam int W = $clog2(WIN);
  localparam logic [W-1:0] LAST = W'(WIN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (cnt_en)
      cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
  end

  assign win_last = cnt_en && (cnt == LAST);

  AST_WIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    win_last |=> (cnt == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt)); // R11
endmodule

// File: rtl/lc_code_matcher.sv
module lc_code_matcher
  import loopcode_pkg::*;
#(
  parameter int ERR_LIM = 1482
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cnt_en,
  input  logic  bit_in,
  input  code_t code,
  input  len_t  len_m1,
  input  logic  win_last,
  output logic  hit
);
  localparam int EW = $clog2(ERR_LIM + 1);
  localparam logic [EW-1:0] LIM = EW'(ERR_LIM);

  len_t              phase;
  logic [CODE_W-1:0] ok;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (cnt_en)
      phase <= (phase >= len_m1) ? '0 : phase + len_t'(1);
  end

  // one mismatch counter per candidate alignment of the pattern
  for (genvar k = 0; k < CODE_W; k++) begin : g_hyp
    len_t          idx;
    logic          exp_bit;
    logic          miss;
    logic [EW-1:0] errs;
    logic [EW-1:0] errs_nxt;

    always_comb begin
      idx      = phase_add(phase, len_t'(k), len_m1);
      exp_bit  = code[len_t'(CODE_W - 1) - idx];
      miss     = cnt_en && (bit_in != exp_bit);
      errs_nxt = (miss && (errs != LIM)) ? errs + EW'(1) : errs;
    end

    always_ff @(posedge clk) begin
      if (rst)
        errs <= '0;
      else if (cnt_en)
        errs <= win_last ? '0 : errs_nxt;
    end

    assign ok[k] = (len_t'(k) <= len_m1) && (errs_nxt < LIM);

    AST_ERR_CAP: assert property (@(posedge clk) disable iff (rst)
      errs <= LIM); // R6
  end

  assign hit = win_last && (|ok);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (phase <= $past(len_m1))); // R4
  AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !hit); // R11
endmodule

// File: rtl/lc_sticky_flag.sv
module lc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else
      flag <= set | (flag & ~clr);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> flag); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> (flag == $past(flag))); // R8
endmodule

// File: rtl/loopcode_watch.sv
module loopcode_watch
  import loopcode_pkg::*;
#(
  parameter int WIN     = 74112,
  parameter int ERR_LIM = WIN / 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       fbit_pos,
  input  logic       framed,
  input  logic [7:0] up_code,
  input  logic [2:0] up_len,
  input  logic [7:0] dn_code,
  input  logic [2:0] dn_len,
  input  logic       up_clr,
  input  logic       dn_clr,
  output logic       up_flag,
  output logic       dn_flag
);
  localparam int NCODE = 2;

  logic              cnt_en;
  logic              win_last;
  code_t             codes [NCODE];
  len_t              lens  [NCODE];
  logic [NCODE-1:0]  clrs;
  logic [NCODE-1:0]  hits;
  logic [NCODE-1:0]  flags;

  assign cnt_en = bit_vld && !(framed && fbit_pos);

  assign codes[0] = up_code;
  assign codes[1] = dn_code;
  assign lens[0]  = up_len;
  assign lens[1]  = dn_len;
  assign clrs     = {dn_clr, up_clr};

  lc_window_timer #(.WIN(WIN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .win_last(win_last)
  );

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    lc_code_matcher #(.ERR_LIM(ERR_LIM)) u_match (
      .clk     (clk),
      .rst     (rst),
      .cnt_en  (cnt_en),
      .bit_in  (bit_in),
      .code    (codes[g]),
      .len_m1  (lens[g]),
      .win_last(win_last),
      .hit     (hits[g])
    );

    lc_sticky_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (hits[g]),
      .clr (clrs[g]),
      .flag(flags[g])
    );
  end

  assign up_flag = flags[0];
  assign dn_flag = flags[1];

  AST_UP_RISE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(up_flag) |-> $past(hits[0])); // R3
  AST_DN_RISE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_flag) |-> $past(hits[1])); // R3
endmodule

// File: tb/tb_loopcode_watch.sv
module tb_loopcode_watch;
  localparam int WIN = 100;
  localparam int LIM = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0, bit_in = 1'b0, fbit_pos = 1'b0, framed = 1'b0;
  logic [7:0] up_code = 8'h80, dn_code = 8'hC0;
  logic [2:0] up_len = 3'd4, dn_len = 3'd2;
  logic       up_clr = 1'b0, dn_clr = 1'b0;
  logic       up_flag, dn_flag;

  loopcode_watch #(.WIN(WIN), .ERR_LIM(LIM)) dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .fbit_pos(fbit_pos), .framed(framed),
    .up_code(up_code), .up_len(up_len), .dn_code(dn_code), .dn_len(dn_len),
    .up_clr(up_clr), .dn_clr(dn_clr), .up_flag(up_flag), .dn_flag(dn_flag)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  up;
    logic  dn;
    string req;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  logic  mu = 1'b0, md = 1'b0;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // monitor: compare queued expectations on the cycle they fall due
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        check(it.req, "up_flag", up_flag, it.up);
        check(it.req, "dn_flag", dn_flag, it.dn);
      end
    end
  end

  task automatic idle();
    bit_vld = 1'b0; fbit_pos = 1'b0; up_clr = 1'b0; dn_clr = 1'b0;
  endtask

  // driver: one window of WIN counted bits, then queue the expected flags
  task automatic send_window(input logic [7:0] pat, input int len, input int off,
                             input int nerr, input bit ins_f, input bit mark_f,
                             input bit gaps, input bit clr_last,
                             input logic hu, input logic hd, input string req);
    int   errs;
    logic b;
    logic f;
    errs = 0;
    for (int j = 0; j < WIN; j++) begin
      b = pat[7 - ((j + off) % len)];
      f = 1'b0;
      if (errs < nerr && (j % 20) == 10) begin b = ~b; errs++; end
      if (mark_f && (j % 20) == 5) begin b = ~b; f = 1'b1; end
      if (ins_f && (j % 20) == 0 && j > 0) begin
        @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1; fbit_pos = 1'b1; up_clr = 1'b0;
      end
      if (gaps && (j % 7) == 3) begin
        @(negedge clk); bit_vld = 1'b0; bit_in = ~bit_in; fbit_pos = 1'b0; up_clr = 1'b0;
      end
      @(negedge clk);
      bit_vld = 1'b1; bit_in = b; fbit_pos = f;
      up_clr = clr_last && (j == WIN - 1);
    end
    mu = mu | hu;
    md = md | hd;
    q.push_back('{cyc + 1, mu, md, req});
    @(negedge clk);
    idle();
  endtask

  task automatic clear(input bit cu, input bit cd, input string req);
    @(negedge clk);
    idle();
    up_clr = cu; dn_clr = cd;
    if (cu) mu = 1'b0;
    if (cd) md = 1'b0;
    q.push_back('{cyc + 1, mu, md, req});
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "up_flag in reset", up_flag, 1'b0);
    check("R1", "dn_flag in reset", dn_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "up_flag after reset", up_flag, 1'b0);
    check("R1", "dn_flag after reset", dn_flag, 1'b0);

    // R3: clean loop-up code 10000 (0x80, length 5)
    send_window(8'h80, 5, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, "R3");
    // R8: window of zeros, flag stays set
    send_window(8'h00, 1, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R8");
    clear(1, 0, "R8");
    // R2 R4: loop-down code 110 (0xC0, length 3), phase offset 1
    send_window(8'hC0, 3, 1, 0, 0, 0, 0, 0, 1'b0, 1'b1, "R2_R4");
    clear(0, 1, "R8");
    // R5: two errors, below limit
    send_window(8'h80, 5, 3, 2, 0, 0, 0, 0, 1'b1, 1'b0, "R5");
    clear(1, 0, "R8");
    // R6: three errors, at limit
    send_window(8'h80, 5, 0, 3, 0, 0, 0, 0, 1'b0, 1'b0, "R6");
    // R7 R11: framed, inserted corrupt framing bits and idle gaps are skipped
    @(negedge clk); framed = 1'b1;
    send_window(8'h80, 5, 2, 0, 1, 0, 1, 0, 1'b1, 1'b0, "R7_R11");
    clear(1, 0, "R8");
    // R7: unframed, marked flipped bits are counted as errors
    @(negedge clk); framed = 1'b0;
    send_window(8'h80, 5, 0, 0, 0, 1, 0, 0, 1'b0, 1'b0, "R7");
    // R2: 8-bit loop-down code 0xA5, phase offset 5
    @(negedge clk); dn_code = 8'hA5; dn_len = 3'd7;
    send_window(8'hA5, 8, 5, 0, 0, 0, 0, 0, 1'b0, 1'b1, "R2");
    // R9 R11: clear on the detecting cycle, set wins
    send_window(8'h80, 5, 1, 0, 0, 0, 1, 1, 1'b1, 1'b0, "R9_R11");
    clear(1, 1, "R8");
    // R10: low code bits beyond the length are ignored
    @(negedge clk); up_code = 8'h87;
    send_window(8'h80, 5, 4, 0, 0, 0, 0, 0, 1'b1, 1'b0, "R10");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule